// File: doc/BRIEF.md
# Addressed Serial-Bus Register Pointer Front End

This block is the slave side of a two-wire serial bus (I2C/SMBus) for a small port-expander style device. It answers to one 7-bit address whose upper five bits are fixed and whose lower two bits come from static select pins, so four copies can share a bus. In a write transfer the first byte after the address is a command that loads a two-bit pointer. Every further byte of that transfer is handed to a four-entry register file through a write strobe. In a read transfer the register named by the pointer is fetched through a read strobe and shifted out most significant bit first.

Both bus lines pass through a two-stage synchronizer and a three-sample majority filter. A separate event stage then derives START, STOP and the SCL edges from the filtered lines. The control state machine has ten states. ST_IDLE waits for START. ST_ADDR shifts in the address byte and ends in ST_ADDR_ACK on a match or in ST_IGNORE otherwise. ST_ADDR_ACK leads to ST_CMD for a write or to ST_RDATA for a read. ST_CMD moves to ST_CMD_ACK on a legal command and to ST_IGNORE on an illegal one. ST_CMD_ACK leads to ST_WDATA. ST_WDATA and ST_WDATA_ACK alternate for each data byte. ST_RDATA leads to ST_RDATA_ACK, which returns to ST_RDATA on a master ACK and goes to ST_IGNORE on a master NACK. From any state, START goes to ST_ADDR and STOP goes to ST_IDLE. Reset forces ST_IDLE.

The register file interface is combinational on the read side: `reg_rdata` must reflect `reg_idx` in the cycle in which `reg_rd` is high.

Top module: `i2c_ptr_slave`

## Requirements
- R1: An address byte whose upper seven bits equal binary 11100 followed by `addr_sel[1]` and then `addr_sel[0]` is acknowledged by pulling SDA low during the ninth clock. Any other address is left unacknowledged, and the rest of that transfer is ignored: no strobes and no SDA drive until the next START.
- R2: The eighth address bit selects the direction: 0 means write (command and data bytes follow) and 1 means read (the slave sends data).
- R3: In a write transfer, the byte after the address is a command. A value of 00h to 03h is acknowledged and is stored as the 2-bit pointer presented on `reg_idx`. The pointer cannot be read over the bus.
- R4: A command byte above 03h is not acknowledged and leaves the pointer unchanged. Every later byte of that transfer is also left unacknowledged and causes no write strobe.
- R5: Each data byte after an accepted command produces exactly one `reg_wr` pulse carrying the byte on `reg_wdata` and the pointer on `reg_idx`, and the byte is acknowledged. The pointer does not advance.
- R6: In a read transfer, each byte is fetched by exactly one `reg_rd` pulse from the register named by the pointer and is sent MSB first. Consecutive bytes return the same register. The pointer survives repeated START and STOP.
- R7: A master NACK after a read byte ends the transfer. SDA stays released and no further read strobe occurs until the next START.
- R8: START (SDA falling while SCL is high) begins a new address phase from any state. STOP (SDA rising while SCL is high) returns to idle, after which clocked bytes without a START are ignored.
- R9: While `rst_n` is low, the bus logic is idle, SDA is released, both strobes are low, and the pointer is cleared to 0. Reset released in the middle of a transfer leaves it idle until the next START.
- R10: SCL and SDA pass through a synchronizer and a 3-sample majority filter, so a pulse lasting one system clock on either line changes neither the bit stream nor the START/STOP detection.
- R11: A transfer at a 400 kHz bus rate, with a 250 MHz system clock, writes and reads correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 2 | Static pins giving the two low address bits |
| scl_raw | input | 1 | Bus clock line as seen at the pad |
| sda_raw | input | 1 | Bus data line as seen at the pad |
| sda_pull_low | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_idx | output | 2 | Register index, equal to the pointer |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data for `reg_idx`, sampled with `reg_rd` |

## Verification
The master's acknowledge decision and the fetch of the next read byte land on the same filtered SCL falling edge. At that edge the state machine must read the ACK bit it latched on the rising edge, and in the same cycle either raise `reg_rd` and load the shifter, or drop to ST_IGNORE. The bench provokes this by reading two bytes with ACK and then NACK, and by clocking a further byte after the NACK. It judges the result by the read-strobe count and by the byte after the NACK arriving as all ones (SDA released).

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } bus_state_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int TAPS        = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_filt
);
    localparam int ONES_W = $clog2(TAPS + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [TAPS-1:0]        taps_q;
    logic [ONES_W-1:0]      ones;
    logic                   filt_q;

    always_comb begin
        ones = '0;
        for (int i = 0; i < TAPS; i++) begin
            ones = ones + ONES_W'(taps_q[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            taps_q <= '1;
            filt_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_raw};
            taps_q <= {taps_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
            filt_q <= (ones > ONES_W'(TAPS / 2));
        end
    end

    assign line_filt = filt_q;

    // R10
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taps_q == {TAPS{filt_q}}) |=> $stable(filt_q));

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  = !scl_q &&  scl_f;
    assign scl_fall  =  scl_q && !scl_f;
    assign start_det =  scl_q &&  scl_f &&  sda_q && !sda_f;
    assign stop_det  =  scl_q &&  scl_f && !sda_q &&  sda_f;

endmodule

// File: rtl/i2c_ptr_fsm.sv
module i2c_ptr_fsm
    import i2c_ptr_pkg::*;
#(
    parameter int         DATA_W     = 8,
    parameter int         IDX_W      = 2,
    parameter int         PIN_W      = 2,
    parameter int         FIXED_W    = 5,
    parameter logic [4:0] FIXED_ADDR = 5'b11100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  addr_sel,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_f,
    output logic              sda_pull_low,
    output logic [IDX_W-1:0]  reg_idx,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    bus_state_t        state_q, state_d;
    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  ptr_q;
    logic              rw_q;
    logic              mnack_q;

    logic byte_full, last_tx, rx_state, addr_hit, cmd_ok, bus_evt;

    assign byte_full = (cnt_q == CNT_W'(DATA_W));
    assign last_tx   = (cnt_q == CNT_W'(DATA_W - 1));
    assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_CMD) || (state_q == ST_WDATA);
    assign addr_hit  = (sh_q[DATA_W-1:1] == {FIXED_ADDR[FIXED_W-1:0], addr_sel});
    assign cmd_ok    = (sh_q[DATA_W-1:IDX_W] == '0);
    assign bus_evt   = start_det || stop_det;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (scl_fall && byte_full) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall) state_d = rw_q ? ST_RDATA : ST_CMD;
                ST_CMD:       if (scl_fall && byte_full) state_d = cmd_ok ? ST_CMD_ACK : ST_IGNORE;
                ST_CMD_ACK:   if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_full) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && last_tx) state_d = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) state_d = mnack_q ? ST_IGNORE : ST_RDATA;
                ST_IGNORE:    state_d = ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // output logic
    always_comb begin
        sda_pull_low = 1'b0;
        reg_wr       = 1'b0;
        reg_rd       = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_pull_low = 1'b1;
            ST_RDATA:                              sda_pull_low = !sh_q[DATA_W-1];
            default:                               sda_pull_low = 1'b0;
        endcase
        if (!bus_evt && scl_fall) begin
            reg_wr = (state_q == ST_WDATA) && byte_full;
            reg_rd = ((state_q == ST_ADDR_ACK) && rw_q) ||
                     ((state_q == ST_RDATA_ACK) && !mnack_q);
        end
    end

    assign reg_idx   = ptr_q;
    assign reg_wdata = sh_q;

    // datapath: shifter, bit counter, pointer, direction, master ack
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            cnt_q   <= '0;
            ptr_q   <= '0;
            rw_q    <= 1'b0;
            mnack_q <= 1'b0;
        end else if (start_det) begin
            cnt_q <= '0;
        end else if (!stop_det) begin
            if (rx_state && scl_rise && !byte_full) begin
                sh_q  <= {sh_q[DATA_W-2:0], sda_f};
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if ((state_q == ST_ADDR) && scl_fall && byte_full) begin
                rw_q <= sh_q[0];
            end
            if ((state_q == ST_CMD) && scl_fall && byte_full && cmd_ok) begin
                ptr_q <= sh_q[IDX_W-1:0];
            end
            if (scl_fall && (((state_q == ST_ADDR_ACK) && !rw_q) ||
                             (state_q == ST_CMD_ACK) || (state_q == ST_WDATA_ACK))) begin
                cnt_q <= '0;
            end
            if (reg_rd) begin
                sh_q  <= reg_rdata;
                cnt_q <= '0;
            end
            if ((state_q == ST_RDATA) && scl_fall && !last_tx) begin
                sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if ((state_q == ST_RDATA_ACK) && scl_rise) begin
                mnack_q <= sda_f;
            end
        end
    end

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_IDLE) && !sda_pull_low);

    // R1
    addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_ACK) && ($past(state_q) == ST_ADDR) |->
        ($past(sh_q[DATA_W-1:1]) == {FIXED_ADDR[FIXED_W-1:0], addr_sel}));

    // R4
    ptr_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr_q) |-> (state_q == ST_CMD_ACK));

    // R5
    wr_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (state_q == ST_WDATA_ACK) && sda_pull_low);

    // R6
    rd_then_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> (state_q == ST_RDATA));

    // R7
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !sda_pull_low && !reg_rd && !reg_wr);

    // R5
    bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DATA_W));

endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave #(
    parameter int         DATA_W      = 8,
    parameter int         NUM_REGS    = 4,
    parameter int         PIN_W       = 2,
    parameter logic [4:0] FIXED_ADDR  = 5'b11100,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_TAPS   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PIN_W-1:0]            addr_sel,
    input  logic                        scl_raw,
    input  logic                        sda_raw,
    output logic                        sda_pull_low,
    output logic [$clog2(NUM_REGS)-1:0] reg_idx,
    output logic                        reg_wr,
    output logic [DATA_W-1:0]           reg_wdata,
    output logic                        reg_rd,
    input  logic [DATA_W-1:0]           reg_rdata
);
    localparam int IDX_W   = $clog2(NUM_REGS);
    localparam int FIXED_W = 7 - PIN_W;

    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_det, stop_det;

    i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .TAPS(FILT_TAPS)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_raw(scl_raw), .line_filt(scl_f));

    i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .TAPS(FILT_TAPS)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_raw(sda_raw), .line_filt(sda_f));

    i2c_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det));

    i2c_ptr_fsm #(
        .DATA_W(DATA_W), .IDX_W(IDX_W), .PIN_W(PIN_W),
        .FIXED_W(FIXED_W), .FIXED_ADDR(FIXED_ADDR)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_f(sda_f),
        .sda_pull_low(sda_pull_low), .reg_idx(reg_idx),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata));

endmodule

// File: tb/test_i2c_ptr_slave.sv
module test_i2c_ptr_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr_sel = 2'b10;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull_low;
    logic [1:0] reg_idx;
    logic       reg_wr, reg_rd;
    logic [7:0] reg_wdata, reg_rdata;
    logic       sda_bus;

    logic [7:0] rf [4];
    int wr_cnt = 0, rd_cnt = 0;
    logic [1:0] last_idx = '0;
    logic [7:0] last_data = '0;
    int errors = 0, checks = 0;
    int q = 40;
    bit done = 0;

    always #2 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_pull_low;
    assign reg_rdata = rf[reg_idx];

    i2c_ptr_slave i_i2c_ptr_slave (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
        .scl_raw(scl_m), .sda_raw(sda_bus), .sda_pull_low(sda_pull_low),
        .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata));

    initial begin
        rf[0] = 8'h81; rf[1] = 8'h00; rf[2] = 8'hC5; rf[3] = 8'h0F;
    end

    always @(posedge clk) begin
        if (reg_wr) begin
            rf[reg_idx] <= reg_wdata;
            wr_cnt      <= wr_cnt + 1;
            last_idx    <= reg_idx;
            last_data   <= reg_wdata;
        end
        if (reg_rd) rd_cnt <= rd_cnt + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold();
        repeat (q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
        sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold();
    endtask

    task automatic send_bit(input logic b, input bit gl);
        sda_m = b;
        if (gl) begin
            repeat (q / 2) @(negedge clk);
            scl_m = 1'b1; @(negedge clk); scl_m = 1'b0;
            repeat (q / 2 - 1) @(negedge clk);
        end else hold();
        scl_m = 1'b1;
        if (gl) begin
            repeat (q / 2) @(negedge clk);
            sda_m = ~b; @(negedge clk); sda_m = b;
            repeat (q / 2 - 1) @(negedge clk);
        end else hold();
        hold(); scl_m = 1'b0; hold();
    endtask

    task automatic recv_bit(output logic b);
        hold(); scl_m = 1'b1; hold(); b = sda_bus; hold(); scl_m = 1'b0; hold();
    endtask

    task automatic wr_byte(input logic [7:0] d, input bit gl, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i], gl && (i == 3 || i == 5));
        sda_m = 1'b1;
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic rd_byte(input logic nack, output logic [7:0] d);
        logic b;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(nack, 1'b0);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] abyte(input logic [1:0] pins, input logic rw);
        return {5'b11100, pins, rw};
    endfunction

    task automatic t_reset();
        logic ack;
        repeat (5) @(negedge clk);
        chk("R9 sda released in reset", sda_pull_low, 0);
        chk("R9 no write strobe in reset", reg_wr, 0);
        chk("R9 no read strobe in reset", reg_rd, 0);
        bus_start();
        wr_byte(abyte(addr_sel, 1'b0), 1'b0, ack);
        chk("R9 no ack while reset held", ack, 0);
        bus_stop();
        rst_n = 1'b1;
        hold();
    endtask

    task automatic t_addr_pins();
        logic ack;
        int w0;
        for (int p = 0; p < 4; p++) begin
            addr_sel = 2'(p);
            hold();
            bus_start();
            wr_byte(abyte(2'(p), 1'b0), 1'b0, ack);
            chk($sformatf("R1 ack with pins=%0d", p), ack, 1);
            bus_stop();
        end
        addr_sel = 2'b10;
        w0 = wr_cnt;
        bus_start();
        wr_byte(abyte(2'b01, 1'b0), 1'b0, ack);
        chk("R1 nack on wrong pin bits", ack, 0);
        wr_byte(8'h01, 1'b0, ack);
        chk("R1 later byte ignored", ack, 0);
        wr_byte(8'h44, 1'b0, ack);
        chk("R1 no write after mismatch", wr_cnt - w0, 0);
        bus_stop();
        bus_start();
        wr_byte({5'b11101, 2'b10, 1'b0}, 1'b0, ack);
        chk("R1 nack on wrong fixed bits", ack, 0);
        bus_stop();
    endtask

    task automatic t_write();
        logic ack;
        int w0 = wr_cnt;
        bus_start();
        wr_byte(abyte(addr_sel, 1'b0), 1'b0, ack);
        chk("R2 write address ack", ack, 1);
        wr_byte(8'h01, 1'b0, ack);
        chk("R3 command 01h ack", ack, 1);
        wr_byte(8'hA5, 1'b0, ack);
        chk("R5 first data ack", ack, 1);
        wr_byte(8'h5A, 1'b0, ack);
        chk("R5 second data ack", ack, 1);
        bus_stop();
        chk("R5 two write strobes", wr_cnt - w0, 2);
        chk("R5 index from pointer", last_idx, 1);
        chk("R5 last written byte", last_data, 8'h5A);
    endtask

    task automatic t_bad_cmd();
        logic ack;
        logic [7:0] d;
        int w0 = wr_cnt;
        bus_start();
        wr_byte(abyte(addr_sel, 1'b0), 1'b0, ack);
        wr_byte(8'h05, 1'b0, ack);
        chk("R4 command 05h nack", ack, 0);
        wr_byte(8'h77, 1'b0, ack);
        chk("R4 data after bad command nack", ack, 0);
        bus_stop();
        chk("R4 no write after bad command", wr_cnt - w0, 0);
        bus_start();
        wr_byte(abyte(addr_sel, 1'b1), 1'b0, ack);
        chk("R2 read address ack", ack, 1);
        rd_byte(1'b1, d);
        chk("R4 pointer still 1", d, 8'h5A);
        bus_stop();
    endtask

    task automatic t_read();
        logic ack;
        logic [7:0] d;
        int r0;
        bus_start();
        wr_byte(abyte(addr_sel, 1'b0), 1'b0, ack);
        wr_byte(8'h02, 1'b0, ack);
        chk("R3 command 02h ack", ack, 1);
        r0 = rd_cnt;
        bus_start();
        wr_byte(abyte(addr_sel, 1'b1), 1'b0, ack);
        chk("R8 repeated start read ack", ack, 1);
        rd_byte(1'b0, d);
        chk("R6 first read byte", d, 8'hC5);
        rd_byte(1'b1, d);
        chk("R6 second read same register", d, 8'hC5);
        chk("R6 one strobe per byte", rd_cnt - r0, 2);
        rd_byte(1'b1, d);
        chk("R7 sda released after nack", d, 8'hFF);
        chk("R7 no strobe after nack", rd_cnt - r0, 2);
        bus_stop();
        wr_byte(abyte(addr_sel, 1'b0), 1'b0, ack);
        chk("R8 bytes after stop ignored", ack, 0);
        bus_start();
        wr_byte(abyte(addr_sel, 1'b1), 1'b0, ack);
        rd_byte(1'b1, d);
        chk("R6 pointer kept across stop", d, 8'hC5);
        bus_stop();
    endtask

    task automatic t_glitch();
        logic ack;
        bus_start();
        wr_byte(abyte(addr_sel, 1'b0), 1'b1, ack);
        chk("R10 address ack with glitches", ack, 1);
        wr_byte(8'h03, 1'b1, ack);
        chk("R10 command ack with glitches", ack, 1);
        wr_byte(8'h96, 1'b1, ack);
        chk("R10 data ack with glitches", ack, 1);
        bus_stop();
        chk("R10 index after glitches", last_idx, 3);
        chk("R10 data after glitches", last_data, 8'h96);
    endtask

    task automatic t_fast_mode();
        logic ack;
        logic [7:0] d;
        q = 156;
        bus_start();
        wr_byte(abyte(addr_sel, 1'b0), 1'b0, ack);
        wr_byte(8'h02, 1'b0, ack);
        wr_byte(8'h3C, 1'b0, ack);
        chk("R11 data ack at 400 kHz", ack, 1);
        bus_start();
        wr_byte(abyte(addr_sel, 1'b1), 1'b0, ack);
        rd_byte(1'b1, d);
        chk("R11 read back at 400 kHz", d, 8'h3C);
        bus_stop();
        q = 40;
    endtask

    task automatic t_reset_mid();
        logic ack;
        logic [7:0] d;
        logic [7:0] a = abyte(addr_sel, 1'b0);
        bus_start();
        for (int i = 7; i >= 0; i--) send_bit(a[i], 1'b0);
        sda_m = 1'b1;
        hold();
        chk("R1 ack driven in ack slot", sda_pull_low, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset releases sda", sda_pull_low, 0);
        hold();
        rst_n = 1'b1;
        hold();
        bus_stop();
        bus_start();
        wr_byte(abyte(addr_sel, 1'b1), 1'b0, ack);
        rd_byte(1'b1, d);
        chk("R9 pointer cleared by reset", d, 8'h81);
        bus_stop();
    endtask

    initial begin
        t_reset();
        t_addr_pins();
        t_write();
        t_bad_cmd();
        t_read();
        t_glitch();
        t_fast_mode();
        t_reset_mid();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule